// File: doc/BRIEF.md
# Paper Tape Reader Controller

This controller sits between an 8-hole paper tape reader and an 18-bit I/O bus. The reader mechanism is modelled as a stream of frames. The controller raises a request, and each frame arrives with a one-cycle valid strobe while the request is up. The processor drives the controller through three decoded one-cycle strobes. One tests the completion flag and returns a skip indication. One returns the assembled buffer onto the data bus. One starts a new read.

A qualifier sampled with the start strobe picks one of two modes.

- **Character mode** takes a single frame. That frame is formatted by a selectable parity policy: pass-through, even parity over the low seven bits, or bit 7 forced high.
- **Word mode** accepts only frames whose tag bit (bit 7) is set. It packs their low six bits into an 18-bit word, most significant slice first. Untagged frames are skipped, and the request stays up.

If the reader reports no tape while a frame is requested, the controller completes at once with an error flag. A position counter tracks accepted frames.

Top module: `tape_reader_ctl`

## Requirements
- R1: After synchronous reset, done_flag, error_flag and frame_req are 0, position is 0, skip_out is 0, and the buffer is 0.
- R2: A start_rd strobe clears done_flag, error_flag and the buffer, and raises frame_req in the next cycle. start_binary=1 selects word mode; start_binary=0 selects character mode.
- R3: In character mode with parity_sel 0 or 3 (pass-through), the single accepted frame is stored unchanged. done_flag rises and frame_req falls in the cycle after the frame.
- R4: With parity_sel=1 (even), bits 6..0 of the frame are kept. Bit 7 is set so that the 8-bit result has an even number of ones.
- R5: With parity_sel=2 (forced), bits 6..0 of the frame are kept and bit 7 is always 1.
- R6: In word mode, successive tagged frames (bit 7 = 1) place their bits 5..0 at buffer bits 17..12, then 11..6, then 5..0. done_flag rises only after the third tagged frame.
- R7: In word mode, a frame with bit 7 = 0 changes nothing: the buffer, position and done_flag stay as they were, and frame_req stays high.
- R8: done_flag and frame_req are never high together.
- R9: One cycle after a read strobe, bus_out equals bus_in OR the buffer, and done_flag is clear. In all other cycles, bus_out equals bus_in from one cycle earlier.
- R10: One cycle after a skip strobe, skip_out is 1 exactly when done_flag was 1 at the strobe. Without a skip strobe, skip_out is 0.
- R11: If tape_present is 0 while frame_req is high, done_flag and error_flag are both set in the next cycle and frame_req drops.
- R12: Strobes that arrive in the same cycle act in the order skip, then read, then start. Skip and read see the state from before the start.
- R13: position increments by one for each accepted frame. A frame that arrives while frame_req is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| skip_tst | input | 1 | Strobe: test done flag |
| read_buf | input | 1 | Strobe: return buffer and clear done |
| start_rd | input | 1 | Strobe: begin a new read |
| start_binary | input | 1 | Mode qualifier for start_rd (1 = word mode) |
| parity_sel | input | 2 | Character formatting: 0/3 pass, 1 even, 2 forced |
| bus_in | input | 18 | Data bus value to be ORed with the buffer |
| bus_out | output | 18 | Registered returned data bus |
| skip_out | output | 1 | Registered skip indication |
| tape_present | input | 1 | Reader reports tape loaded |
| frame_req | output | 1 | Controller wants a frame |
| frame_valid | input | 1 | Frame strobe from reader |
| frame_data | input | 8 | Frame contents |
| done_flag | output | 1 | Read complete / interrupt request |
| error_flag | output | 1 | Out-of-tape error |
| position | output | 16 | Count of accepted frames |

## Verification
Some internal faults show up late. A wrong slice counter misplaces a six-bit slice in the word, and also makes done_flag rise one frame early or late. That becomes visible at the read strobe that follows the third tagged frame. A wrong parity or tag decision is visible in the byte returned by the very next read. Stuck request or flag state violates the exclusion between done_flag and frame_req within one cycle. A bad strobe ordering changes skip_out or bus_out in the cycle right after a combined strobe.

// File: rtl/tape_rdr_pkg.sv
package tape_rdr_pkg;
  typedef enum logic [1:0] {
    PAR_PASS   = 2'd0,
    PAR_EVEN   = 2'd1,
    PAR_FORCE  = 2'd2,
    PAR_PASS2  = 2'd3
  } par_mode_e;
endpackage

// File: rtl/tape_char_fmt.sv
module tape_char_fmt
  import tape_rdr_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic [FRAME_W-1:0] raw,
  input  logic [1:0]         sel,
  output logic [FRAME_W-1:0] chr
);
  localparam int TOP = FRAME_W - 1;
  par_mode_e mode;

  always_comb begin
    mode = par_mode_e'(sel);
    chr  = raw;
    case (mode)
      PAR_EVEN:  chr = {^raw[TOP-1:0], raw[TOP-1:0]};
      PAR_FORCE: chr = {1'b1, raw[TOP-1:0]};
      default:   chr = raw;
    endcase
  end
endmodule

// File: rtl/tape_word_pack.sv
module tape_word_pack #(
  parameter int WORD_W  = 18,
  parameter int SLICE_W = 6,
  parameter int CNT_W   = 5
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [WORD_W-1:0]  acc,
  input  logic [SLICE_W-1:0] slice,
  output logic [CNT_W-1:0]   cnt_nxt,
  output logic [WORD_W-1:0]  acc_nxt
);
  logic [WORD_W-1:0] wide;

  always_comb begin
    cnt_nxt = cnt - CNT_W'(SLICE_W);
    wide    = WORD_W'(slice);
    acc_nxt = acc | (wide << cnt_nxt);
  end
endmodule

// File: rtl/tape_reader_ctl.sv
module tape_reader_ctl
  import tape_rdr_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int FRAME_W = 8,
  parameter int SLICE_W = 6,
  parameter int POS_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               skip_tst,
  input  logic               read_buf,
  input  logic               start_rd,
  input  logic               start_binary,
  input  logic [1:0]         parity_sel,
  input  logic [WORD_W-1:0]  bus_in,
  output logic [WORD_W-1:0]  bus_out,
  output logic               skip_out,
  input  logic               tape_present,
  output logic               frame_req,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  output logic               done_flag,
  output logic               error_flag,
  output logic [POS_W-1:0]   position
);
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int TAG_BIT = FRAME_W - 1;

  logic               req_q, bin_q, done_q, err_q, skip_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WORD_W-1:0]  buf_q, bus_q;
  logic [POS_W-1:0]   pos_q;

  logic [FRAME_W-1:0] chr;
  logic [CNT_W-1:0]   cnt_nxt;
  logic [WORD_W-1:0]  acc_nxt;
  logic               take, accept, finish, starve;

  tape_char_fmt #(.FRAME_W(FRAME_W)) u_fmt (
    .raw (frame_data),
    .sel (parity_sel),
    .chr (chr)
  );

  tape_word_pack #(.WORD_W(WORD_W), .SLICE_W(SLICE_W), .CNT_W(CNT_W)) u_pack (
    .cnt     (cnt_q),
    .acc     (buf_q),
    .slice   (frame_data[SLICE_W-1:0]),
    .cnt_nxt (cnt_nxt),
    .acc_nxt (acc_nxt)
  );

  always_comb begin
    starve = req_q && !tape_present && !start_rd;
    take   = req_q && tape_present && frame_valid && !start_rd;
    accept = take && (!bin_q || frame_data[TAG_BIT]);
    finish = accept && (!bin_q || (cnt_nxt == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      bin_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      skip_q <= 1'b0;
      cnt_q  <= '0;
      buf_q  <= '0;
      bus_q  <= '0;
      pos_q  <= '0;
    end else begin
      // skip samples the flag first, then read, then start
      skip_q <= skip_tst & done_q;
      bus_q  <= read_buf ? (bus_in | buf_q) : bus_in;
      if (read_buf) done_q <= 1'b0;
      if (start_rd) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
        buf_q  <= '0;
        bin_q  <= start_binary;
        cnt_q  <= start_binary ? CNT_W'(WORD_W) : '0;
        req_q  <= 1'b1;
      end else if (starve) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
        req_q  <= 1'b0;
      end else if (accept) begin
        pos_q <= pos_q + POS_W'(1);
        if (bin_q) begin
          cnt_q <= cnt_nxt;
          buf_q <= acc_nxt;
        end else begin
          buf_q <= WORD_W'(chr);
        end
        if (finish) begin
          done_q <= 1'b1;
          req_q  <= 1'b0;
        end
      end
    end
  end

  assign bus_out    = bus_q;
  assign skip_out   = skip_q;
  assign frame_req  = req_q;
  assign done_flag  = done_q;
  assign error_flag = err_q;
  assign position   = pos_q;
endmodule

// File: rtl/tape_reader_chk.sv
module tape_reader_chk #(
  parameter int FRAME_W = 8,
  parameter int POS_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               skip_tst,
  input logic               start_rd,
  input logic               skip_out,
  input logic               tape_present,
  input logic               frame_req,
  input logic               frame_valid,
  input logic [FRAME_W-1:0] frame_data,
  input logic               done_flag,
  input logic               error_flag,
  input logic [POS_W-1:0]   position,
  input logic               bin_q
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_rd |=> (!done_flag && !error_flag && frame_req)); // R2

  AST_REQ_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(frame_req && done_flag)); // R8

  AST_SKIP_HIT: assert property (@(posedge clk) disable iff (rst)
    (skip_tst && done_flag) |=> skip_out); // R10

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !skip_tst |=> !skip_out); // R10

  AST_NO_TAPE: assert property (@(posedge clk) disable iff (rst)
    (frame_req && !tape_present && !start_rd) |=> (done_flag && error_flag && !frame_req)); // R11

  AST_UNTAGGED_SKIP: assert property (@(posedge clk) disable iff (rst)
    (frame_req && bin_q && tape_present && frame_valid && !frame_data[FRAME_W-1] && !start_rd)
      |=> ($stable(position) && frame_req)); // R7

  AST_IDLE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!frame_req && !start_rd) |=> $stable(position)); // R13
endmodule

bind tape_reader_ctl tape_reader_chk #(.FRAME_W(FRAME_W), .POS_W(POS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .skip_tst     (skip_tst),
  .start_rd     (start_rd),
  .skip_out     (skip_out),
  .tape_present (tape_present),
  .frame_req    (frame_req),
  .frame_valid  (frame_valid),
  .frame_data   (frame_data),
  .done_flag    (done_flag),
  .error_flag   (error_flag),
  .position     (position),
  .bin_q        (bin_q)
);

// File: tb/tape_reader_ctl_tb.sv
module tape_reader_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        skip_tst = 0, read_buf = 0, start_rd = 0, start_binary = 0;
  logic [1:0]  parity_sel = 2'd0;
  logic [17:0] bus_in = '0;
  logic [17:0] bus_out;
  logic        skip_out, frame_req, done_flag, error_flag;
  logic        tape_present = 1'b1, frame_valid = 1'b0;
  logic [7:0]  frame_data = '0;
  logic [15:0] position;

  int nchk = 0, nfail = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  tape_reader_ctl u_dut (
    .clk(clk), .rst(rst), .skip_tst(skip_tst), .read_buf(read_buf),
    .start_rd(start_rd), .start_binary(start_binary), .parity_sel(parity_sel),
    .bus_in(bus_in), .bus_out(bus_out), .skip_out(skip_out),
    .tape_present(tape_present), .frame_req(frame_req), .frame_valid(frame_valid),
    .frame_data(frame_data), .done_flag(done_flag), .error_flag(error_flag),
    .position(position)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic do_start(bit bin);
    @(negedge clk); start_rd = 1; start_binary = bin;
    @(negedge clk); start_rd = 0;
  endtask

  task automatic feed(logic [7:0] d);
    frame_valid = 1; frame_data = d;
    @(negedge clk); frame_valid = 0;
  endtask

  task automatic rd(output logic [17:0] v);
    read_buf = 1;
    @(negedge clk); read_buf = 0; v = bus_out;
  endtask

  task automatic t_reset();
    chk("R1 done", done_flag, 0);
    chk("R1 err", error_flag, 0);
    chk("R1 req", frame_req, 0);
    chk("R1 pos", position, 0);
    chk("R1 skip", skip_out, 0);
    chk("R1 bus", bus_out, 0);
  endtask

  task automatic t_alpha(logic [1:0] ps, logic [7:0] d, logic [7:0] exp, string tag);
    logic [17:0] v;
    logic [15:0] p0;
    parity_sel = ps;
    do_start(0);
    chk({tag, " R2 req"}, frame_req, 1);
    p0 = position;
    feed(d);
    chk({tag, " R3 done"}, done_flag, 1);
    chk({tag, " R3 req drop"}, frame_req, 0);
    chk({tag, " R13 pos"}, position, p0 + 16'd1);
    rd(v);
    chk({tag, " data"}, v, {10'd0, exp});
    chk({tag, " R9 done clr"}, done_flag, 0);
  endtask

  task automatic t_binary();
    logic [17:0] v;
    logic [15:0] p0;
    do_start(1);
    p0 = position;
    feed(8'h81);
    chk("R6 not done 1", done_flag, 0);
    feed(8'h05);
    chk("R7 untagged req", frame_req, 1);
    chk("R7 untagged pos", position, p0 + 16'd1);
    chk("R7 untagged done", done_flag, 0);
    feed(8'hAA);
    chk("R6 not done 2", done_flag, 0);
    feed(8'hFF);
    chk("R6 done", done_flag, 1);
    chk("R13 pos3", position, p0 + 16'd3);
    rd(v);
    chk("R6 word", v, 18'h1ABF);
  endtask

  task automatic t_skip_and_or();
    logic [17:0] v;
    parity_sel = 0;
    do_start(0);
    skip_tst = 1; @(negedge clk); skip_tst = 0;
    chk("R10 skip while busy", skip_out, 0);
    feed(8'h3C);
    skip_tst = 1; @(negedge clk); skip_tst = 0;
    chk("R10 skip when done", skip_out, 1);
    @(negedge clk);
    chk("R10 skip idle", skip_out, 0);
    bus_in = 18'h30000;
    rd(v);
    chk("R9 or bus", v, 18'h3003C);
    @(negedge clk);
    chk("R9 passthrough", bus_out, 18'h30000);
    bus_in = '0;
  endtask

  task automatic t_idle_frame();
    logic [17:0] v;
    logic [15:0] p0;
    p0 = position;
    feed(8'h77);
    chk("R13 idle frame pos", position, p0);
    rd(v);
    chk("R13 idle frame buf", v, 18'h3C);
  endtask

  task automatic t_no_tape();
    tape_present = 0;
    do_start(1);
    @(negedge clk);
    chk("R11 done", done_flag, 1);
    chk("R11 err", error_flag, 1);
    chk("R11 req", frame_req, 0);
    tape_present = 1;
    do_start(0);
    chk("R2 err cleared", error_flag, 0);
    feed(8'h12);
  endtask

  task automatic t_combined();
    logic [17:0] v;
    skip_tst = 1; read_buf = 1; start_rd = 1; start_binary = 1;
    @(negedge clk);
    skip_tst = 0; read_buf = 0; start_rd = 0;
    chk("R12 skip old done", skip_out, 1);
    chk("R12 read old buf", bus_out, 18'h12);
    chk("R12 start done clr", done_flag, 0);
    chk("R12 start req", frame_req, 1);
    rd(v);
    chk("R2 buffer cleared", v, 0);
  endtask

  task automatic t_reset_abort();
    rst = 1; @(negedge clk); rst = 0;
    chk("R1 abort req", frame_req, 0);
    chk("R1 abort pos", position, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_alpha(2'd0, 8'hC5, 8'hC5, "R3 plain");
    t_alpha(2'd3, 8'h5A, 8'h5A, "R3 plain3");
    t_alpha(2'd1, 8'h83, 8'h03, "R4 even2");
    t_alpha(2'd1, 8'h01, 8'h81, "R4 even1");
    t_alpha(2'd1, 8'h7F, 8'hFF, "R4 even7");
    t_alpha(2'd2, 8'h41, 8'hC1, "R5 forced");
    t_binary();
    t_skip_and_or();
    t_idle_frame();
    t_no_tape();
    t_combined();
    t_reset_abort();
    finish_run();
  end
endmodule